// File: doc/BRIEF.md
# Data Access Error Trap Reporter

This block sits next to a data memory interface and turns failed data accesses into trap requests for the CPU. Each completed access is marked as a load or a store. It arrives with three error indications: a control-register access error, a system bus error and a scratch-memory address range error.

A failed load raises a synchronous trap in the same cycle, identified by trap number 2. A failed store raises an asynchronous trap, identified by trap number 3. The asynchronous trap stays pending until the CPU acknowledges it. Each trap class keeps its causes in its own sticky flag register. Software reads these registers over a small register port and clears them by writing ones.

Top module: `dacc_err_trap`

## Requirements
- R1: When `acc_valid_i` is high, `acc_store_i` is low and any bit of `err_src_i` is set, `sync_trap_o` is high in that same cycle and `trap_tin_o` reads 2. `sync_trap_o` is low in every other cycle.
- R2: A store access with any error bit set makes `async_trap_o` high from the next cycle on. While `async_trap_o` is high and `sync_trap_o` is low, `trap_tin_o` reads 3. When both are high, the synchronous number 2 wins. With neither high, `trap_tin_o` is 0.
- R3: The synchronous flag register records load errors one cycle after the access. Bit 0 is the control-register error, bit 1 the bus error and bit 2 the range error. A set bit stays set until it is cleared.
- R4: The asynchronous flag register records store errors with the same bit positions. A load error never changes the asynchronous flags or the pending asynchronous request, and a store error never changes the synchronous flags.
- R5: When several error bits are set on one access, every matching flag bit is set and a single trap request results.
- R6: A store error that arrives while an asynchronous trap is pending ORs its cause bits into the asynchronous flags. `async_trap_o` stays high without dropping.
- R7: A write with `reg_wr_i` high clears each flag bit of the selected register whose `reg_wdata_i` bit is 1 and leaves the bits written 0. An error that sets a bit in the same cycle takes precedence over its clear.
- R8: `reg_rdata_o` shows the synchronous flags when `reg_sel_i` is 0 and the asynchronous flags when it is 1, in the same cycle.
- R9: `async_ack_i` while a request is pending makes `async_trap_o` low in the next cycle, unless a store error arrives in the same cycle, in which case it stays high. An acknowledge with nothing pending has no effect.
- R10: While and after reset, all flags are 0, `sync_trap_o` and `async_trap_o` are low and `trap_tin_o` is 0.
- R11: An access with no error bit set, or error bits presented while `acc_valid_i` is low, raises no trap and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | A data access completes this cycle |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| err_src_i | input | N_SRC (3) | Error indications: bit 0 control register, bit 1 bus, bit 2 range |
| async_ack_i | input | 1 | CPU acknowledges the asynchronous trap |
| reg_wr_i | input | 1 | Write-one-to-clear strobe for the selected flag register |
| reg_sel_i | input | 1 | Register select: 0 synchronous flags, 1 asynchronous flags |
| reg_wdata_i | input | N_SRC (3) | Clear mask |
| reg_rdata_o | output | N_SRC (3) | Selected flag register |
| sync_trap_o | output | 1 | Synchronous trap request, one-cycle pulse |
| async_trap_o | output | 1 | Asynchronous trap request, level |
| trap_tin_o | output | TIN_W (4) | Trap identification number of the active request |

## Verification
The bench builds the block with its default parameters: three error sources, a 4-bit trap number, and the numbers 2 and 3. With these values every source bit, and combinations of them, can be driven directly. Both trap numbers and the zero idle value can be told apart on `trap_tin_o`. The collisions of interest all come within a few cycles of each other: set against clear, store error against acknowledge, and load pulse over a pending store trap.

// File: rtl/dacc_err_pkg.sv
package dacc_err_pkg;
  localparam int unsigned SRC_CTRL  = 0;
  localparam int unsigned SRC_BUS   = 1;
  localparam int unsigned SRC_RANGE = 2;
  localparam int unsigned NUM_SRC   = 3;
  localparam int unsigned NUM_CLS   = 2;

  typedef enum logic {
    CLS_SYNC  = 1'b0,
    CLS_ASYNC = 1'b1
  } err_cls_e;
endpackage

// File: rtl/dacc_err_classify.sv
module dacc_err_classify #(
  parameter int unsigned N_SRC = dacc_err_pkg::NUM_SRC
) (
  input  logic                                              acc_valid_i,
  input  logic                                              acc_store_i,
  input  logic [N_SRC-1:0]                                  err_src_i,
  output logic                                              load_hit_o,
  output logic                                              store_hit_o,
  output logic [dacc_err_pkg::NUM_CLS-1:0][N_SRC-1:0]       set_o
);
  import dacc_err_pkg::*;

  logic any_err;
  assign any_err     = |err_src_i;
  assign load_hit_o  = acc_valid_i & ~acc_store_i & any_err;
  assign store_hit_o = acc_valid_i &  acc_store_i & any_err;

  always_comb begin
    set_o = '0;
    if (load_hit_o)  set_o[CLS_SYNC]  = err_src_i;
    if (store_hit_o) set_o[CLS_ASYNC] = err_src_i;
  end
endmodule

// File: rtl/dacc_flag_reg.sv
module dacc_flag_reg #(
  parameter int unsigned N_SRC = dacc_err_pkg::NUM_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] flags_o
);
  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    logic flag_q;
    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flag_q <= 1'b0;
      else if (set_i[b])     flag_q <= 1'b1;
      else if (clr_i[b])     flag_q <= 1'b0;
    end
    assign flags_o[b] = flag_q;
  end
endmodule

// File: rtl/dacc_async_pend.sv
module dacc_async_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (ack_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dacc_err_trap.sv
module dacc_err_trap #(
  parameter int unsigned N_SRC     = dacc_err_pkg::NUM_SRC,
  parameter int unsigned TIN_W     = 4,
  parameter int unsigned SYNC_TIN  = 2,
  parameter int unsigned ASYNC_TIN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_store_i,
  input  logic [N_SRC-1:0] err_src_i,
  input  logic             async_ack_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [N_SRC-1:0] reg_wdata_i,
  output logic [N_SRC-1:0] reg_rdata_o,
  output logic             sync_trap_o,
  output logic             async_trap_o,
  output logic [TIN_W-1:0] trap_tin_o
);
  import dacc_err_pkg::*;

  localparam logic [TIN_W-1:0] TinSync  = TIN_W'(SYNC_TIN);
  localparam logic [TIN_W-1:0] TinAsync = TIN_W'(ASYNC_TIN);

  logic                           load_hit, store_hit, async_pend;
  logic [NUM_CLS-1:0][N_SRC-1:0]  set_vec, clr_vec, flags;

  dacc_err_classify #(.N_SRC(N_SRC)) u_classify (
    .acc_valid_i (acc_valid_i),
    .acc_store_i (acc_store_i),
    .err_src_i   (err_src_i),
    .load_hit_o  (load_hit),
    .store_hit_o (store_hit),
    .set_o       (set_vec)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    assign clr_vec[c] = (reg_wr_i && (reg_sel_i == c[0])) ? reg_wdata_i : '0;

    dacc_flag_reg #(.N_SRC(N_SRC)) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec[c]),
      .clr_i   (clr_vec[c]),
      .flags_o (flags[c])
    );
  end

  dacc_async_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (store_hit),
    .ack_i  (async_ack_i),
    .pend_o (async_pend)
  );

  assign reg_rdata_o  = reg_sel_i ? flags[CLS_ASYNC] : flags[CLS_SYNC];
  assign sync_trap_o  = load_hit;
  assign async_trap_o = async_pend;

  always_comb begin
    if (load_hit)        trap_tin_o = TinSync;
    else if (async_pend) trap_tin_o = TinAsync;
    else                 trap_tin_o = '0;
  end
endmodule

// File: rtl/dacc_err_trap_chk.sv
module dacc_err_trap_chk #(
  parameter int unsigned N_SRC     = 3,
  parameter int unsigned TIN_W     = 4,
  parameter int unsigned SYNC_TIN  = 2,
  parameter int unsigned ASYNC_TIN = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_store_i,
  input logic [N_SRC-1:0] err_src_i,
  input logic             async_ack_i,
  input logic             reg_wr_i,
  input logic             reg_sel_i,
  input logic [N_SRC-1:0] reg_rdata_o,
  input logic             sync_trap_o,
  input logic             async_trap_o,
  input logic [TIN_W-1:0] trap_tin_o
);
  logic store_err;
  assign store_err = acc_valid_i && acc_store_i && (|err_src_i);

  AST_SYNC_TIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_trap_o |-> trap_tin_o == TIN_W'(SYNC_TIN)); // R1

  AST_STORE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_err |=> async_trap_o); // R2

  AST_ASYNC_TIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_trap_o && !sync_trap_o) |-> trap_tin_o == TIN_W'(ASYNC_TIN)); // R2

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i && !(acc_valid_i && (|err_src_i)))
      |=> (reg_sel_i != $past(reg_sel_i)) || $stable(reg_rdata_o)); // R3

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_trap_o && !async_ack_i) |=> async_trap_o); // R6

  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_trap_o && async_ack_i && !store_err) |=> !async_trap_o); // R9

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_trap_o && !store_err) |=> !async_trap_o); // R11

  AST_IDLE_TIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_trap_o && !async_trap_o) |-> trap_tin_o == '0); // R2
endmodule

bind dacc_err_trap dacc_err_trap_chk #(
  .N_SRC(N_SRC), .TIN_W(TIN_W), .SYNC_TIN(SYNC_TIN), .ASYNC_TIN(ASYNC_TIN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_store_i  (acc_store_i),
  .err_src_i    (err_src_i),
  .async_ack_i  (async_ack_i),
  .reg_wr_i     (reg_wr_i),
  .reg_sel_i    (reg_sel_i),
  .reg_rdata_o  (reg_rdata_o),
  .sync_trap_o  (sync_trap_o),
  .async_trap_o (async_trap_o),
  .trap_tin_o   (trap_tin_o)
);

// File: tb/dacc_err_trap_tb_top.sv
module dacc_err_trap_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_store = 1'b0, async_ack = 1'b0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [2:0] err_src = '0, reg_wdata = '0;
  logic [2:0] reg_rdata;
  logic       sync_trap, async_trap;
  logic [3:0] trap_tin;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacc_err_trap dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .acc_valid_i  (acc_valid),
    .acc_store_i  (acc_store),
    .err_src_i    (err_src),
    .async_ack_i  (async_ack),
    .reg_wr_i     (reg_wr),
    .reg_sel_i    (reg_sel),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .sync_trap_o  (sync_trap),
    .async_trap_o (async_trap),
    .trap_tin_o   (trap_tin)
  );

  typedef struct {
    logic       sync;
    logic       async;
    logic [3:0] tin;
    logic [2:0] rdata;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  logic [2:0] m_sflags = '0, m_aflags = '0;
  logic       m_pend = 1'b0;

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual sync=%b async=%b tin=%0d rdata=%b expected sync=%b async=%b tin=%0d rdata=%b",
               tag, act[9], act[8], act[7:4], act[2:0], exp[9], exp[8], exp[7:4], exp[2:0]);
    end
  endtask

  task automatic cyc(input logic v, input logic st, input logic [2:0] e,
                     input logic wr, input logic sel, input logic [2:0] wd,
                     input logic ack, input string tag);
    exp_t it;
    logic ld_hit, st_hit;
    logic [2:0] clr_s, clr_a;
    @(negedge clk);
    acc_valid = v; acc_store = st; err_src = e;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; async_ack = ack;
    ld_hit = v && !st && (e != 3'b000);
    st_hit = v &&  st && (e != 3'b000);
    it.sync  = ld_hit;
    it.async = m_pend;
    it.tin   = ld_hit ? 4'd2 : (m_pend ? 4'd3 : 4'd0);
    it.rdata = sel ? m_aflags : m_sflags;
    it.tag   = tag;
    exp_q.push_back(it);
    clr_s = (wr && !sel) ? wd : 3'b000;
    clr_a = (wr &&  sel) ? wd : 3'b000;
    m_sflags = (m_sflags & ~clr_s) | (ld_hit ? e : 3'b000);
    m_aflags = (m_aflags & ~clr_a) | (st_hit ? e : 3'b000);
    m_pend   = st_hit ? 1'b1 : (ack ? 1'b0 : m_pend);
  endtask

  task automatic idle(input logic sel, input string tag);
    cyc(1'b0, 1'b0, 3'b000, 1'b0, sel, 3'b000, 1'b0, tag);
  endtask

  // monitor: compare each cycle's outputs against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check(it.tag, {sync_trap, async_trap, trap_tin, 1'b0, reg_rdata},
                      {it.sync, it.async, it.tin, 1'b0, it.rdata});
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R10: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R10 during reset", {sync_trap, async_trap, trap_tin, 1'b0, reg_rdata}, 10'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1'b0, "R10 sync flags after reset");
    idle(1'b1, "R10 async flags after reset");

    // R11: errors without valid, valid without errors
    cyc(1'b0, 1'b0, 3'b111, 1'b0, 1'b0, 3'b000, 1'b0, "R11 error while not valid");
    cyc(1'b1, 1'b1, 3'b000, 1'b0, 1'b1, 3'b000, 1'b0, "R11 clean store");
    cyc(1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, "R11 clean load");
    idle(1'b0, "R11 sync flags untouched");
    idle(1'b1, "R11 async flags untouched");

    // R1 / R3: single load error, control-register source
    cyc(1'b1, 1'b0, 3'b001, 1'b0, 1'b0, 3'b000, 1'b0, "R1 load error pulse");
    idle(1'b0, "R3 sync flag bit0 set, pulse gone");
    idle(1'b1, "R4 load leaves async flags");
    cyc(1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1, "R9 ack with nothing pending");
    idle(1'b0, "R3 flag sticky");

    // R5: multiple sources at once
    cyc(1'b1, 1'b0, 3'b110, 1'b0, 1'b0, 3'b000, 1'b0, "R5 multi-source load");
    idle(1'b0, "R5 all matching bits set");

    // R7: write-one-to-clear
    cyc(1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 3'b010, 1'b0, "R7 clear bus bit");
    idle(1'b0, "R7 bus bit cleared, others kept");
    cyc(1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 3'b000, 1'b0, "R7 write zeros");
    idle(1'b0, "R7 zeros leave flags");
    cyc(1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 3'b101, 1'b0, "R7 set vs clear same cycle");
    idle(1'b0, "R7 set wins over clear");
    cyc(1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 3'b111, 1'b0, "R8 clear of async leaves sync");
    idle(1'b0, "R8 sync flags unchanged by async write");

    // R2 / R4: store error
    cyc(1'b1, 1'b1, 3'b010, 1'b0, 1'b1, 3'b000, 1'b0, "R2 store error");
    idle(1'b1, "R2 async request level, tin 3");
    idle(1'b0, "R4 store leaves sync flags");
    idle(1'b1, "R2 request held");

    // R6: second store error while pending
    cyc(1'b1, 1'b1, 3'b100, 1'b0, 1'b1, 3'b000, 1'b0, "R6 store error while pending");
    idle(1'b1, "R6 causes ORed, request held");

    // R2 priority: load error while async pending
    cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b1, 3'b000, 1'b0, "R2 sync number wins");
    idle(1'b0, "R3 load bus bit recorded");

    // R9: acknowledge
    cyc(1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 3'b000, 1'b1, "R9 ack pending");
    idle(1'b1, "R9 request dropped");
    cyc(1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 3'b000, 1'b0, "R2 new store error");
    cyc(1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 3'b000, 1'b1, "R9 ack with store error");
    idle(1'b1, "R9 request kept pending");
    cyc(1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 3'b011, 1'b1, "R7 clear async bits");
    idle(1'b1, "R7 async range bit kept");
    idle(1'b0, "R8 sync flags readback");
    idle(1'b1, "R9 request dropped again");

    repeat (3) @(negedge clk);
    #5;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule